// File: doc/BRIEF.md
# Conversion Result Status Tracker

This block keeps the status word that belongs to a converter's output data register. Whenever the conversion engine writes a new result, the block stores the 24-bit word, the channel that produced it and whether the value was clamped. From that stored state it builds an 8-bit status word: a ready flag, an error flag, a missing-reference flag, a parity bit and a 4-bit channel tag.

The ready flag is a handshake. A result write clears it. A read of the data register sets it again, and so does an advance warning that a new result is about to be written. Power-down, idle and an active-low sync input hold it set. A read strobe also starts a serial shift of the stored result, MSB first. When the append option is on, the status word follows the result in the same shift.

Top module: `adc_stat_core`

## Requirements
- R1: After reset the status word is 0x80, the stored result is 0, `ser_busy` is 0 and `ser_out` is 0.
- R2: The status word has ready in bit 7 (0 means fresh data is available), error in bit 6, no-reference in bit 5, parity in bit 4 and the channel tag in bits 3..0. The shifted status word follows the same layout, bit 7 first.
- R3: When `wr_stb` is high and no force condition holds, ready is 0 in the next cycle.
- R4: When `rd_stb` or `warn_stb` is high without `wr_stb`, ready is 1 in the next cycle.
- R5: While `pwr_down` is high, `idle` is high or `sync_n` is low, ready is set in the next cycle. This holds even if a result is written in that cycle.
- R6: On each result write, the error bit is loaded with 1 if `wr_clamp` is high or a missing reference is detected, and with 0 otherwise.
- R7: The no-reference bit equals `refdet_en & ref_low` as sampled on the previous clock edge. A result written while `refdet_en & ref_low` is high is stored as all ones. When `refdet_en` is 0, the bit reads 0 and the written result is stored unchanged.
- R8: When `par_en` is 1, the parity bit is 1 if the stored result holds an odd number of ones. When `par_en` is 0, the parity bit is 0.
- R9: The channel tag is loaded from `wr_chan` only on a result write.
- R10: A `rd_stb` loads a shift frame. From the next cycle, `ser_out` presents the stored result MSB first, one bit per cycle. When `append_en` is 1, the 8-bit status word as it stood in the read cycle follows the result. `ser_busy` is high for exactly 24 cycles (or 32 with append) and `ser_out` is 0 while idle.
- R11: A read and a write in the same cycle leave ready at 0.
- R12: Without `wr_stb`, the stored result, error bit and channel tag stay unchanged, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | New result write strobe |
| wr_data | input | 24 | Result word to store |
| wr_chan | input | 4 | Channel that produced the result |
| wr_clamp | input | 1 | Result was clamped by over- or underrange |
| ref_low | input | 1 | Reference is below threshold |
| rd_stb | input | 1 | Data register read strobe |
| warn_stb | input | 1 | Warning pulse ahead of a result write |
| pwr_down | input | 1 | Power-down mode |
| idle | input | 1 | Idle mode |
| sync_n | input | 1 | Sync, active low |
| par_en | input | 1 | Parity enable |
| refdet_en | input | 1 | Reference detection enable |
| append_en | input | 1 | Append status word to serial read |
| status_byte | output | 8 | Current status word |
| data_q | output | 24 | Stored result |
| ser_out | output | 1 | Serial read data, MSB first |
| ser_busy | output | 1 | Serial shift in progress |

## Verification
The bench builds the block with the default 24-bit result width. This makes the 32-bit appended frame and the 24-bit plain frame the exact shift lengths checked bit by bit. With this width, a single set low bit (0x000001) is enough to tell a reference clamp apart from a stored value. Chosen result words with odd and even counts of ones exercise both parity outcomes.

// File: rtl/adc_stat_pkg.sv
package adc_stat_pkg;
  localparam int STAT_W    = 8;
  localparam int CHAN_W    = 4;
  localparam int RDY_BIT   = 7;
  localparam int ERR_BIT   = 6;
  localparam int NOREF_BIT = 5;
  localparam int PAR_BIT   = 4;

  // Odd-ones detector over a zero-extended word
  function automatic logic odd_ones(input logic [63:0] v);
    return ^v;
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(
    input logic rdy, input logic err, input logic noref,
    input logic par, input logic [CHAN_W-1:0] chan);
    logic [STAT_W-1:0] s;
    s = '0;
    s[RDY_BIT]        = rdy;
    s[ERR_BIT]        = err;
    s[NOREF_BIT]      = noref;
    s[PAR_BIT]        = par;
    s[CHAN_W-1:0]     = chan;
    return s;
  endfunction
endpackage

// File: rtl/adc_stat_rdy.sv
module adc_stat_rdy (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stb,
  input  logic rd_stb,
  input  logic warn_stb,
  input  logic force_set,
  output logic rdy_q
);
  logic clr_evt, set_evt;
  assign clr_evt = wr_stb & ~force_set;
  assign set_evt = force_set | (~wr_stb & (rd_stb | warn_stb));

  always_ff @(posedge clk) begin
    if (!rst_n)       rdy_q <= 1'b1;
    else if (set_evt) rdy_q <= 1'b1;
    else if (clr_evt) rdy_q <= 1'b0;
  end

  a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !force_set) |=> !rdy_q);
  a_r4_read_warn_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_stb || warn_stb) && !wr_stb) |=> rdy_q);
  a_r5_force_holds: assert property (@(posedge clk) disable iff (!rst_n)
    force_set |=> rdy_q);
  a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && wr_stb && !force_set) |=> !rdy_q);
endmodule

// File: rtl/adc_stat_store.sv
module adc_stat_store
  import adc_stat_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic              wr_clamp,
  input  logic              ref_low,
  input  logic              refdet_en,
  input  logic              par_en,
  output logic [DATA_W-1:0] data_q,
  output logic              err_q,
  output logic              noref_q,
  output logic [CHAN_W-1:0] chan_q,
  output logic              par_bit
);
  logic noref_now;
  assign noref_now = refdet_en & ref_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      err_q   <= 1'b0;
      chan_q  <= '0;
      noref_q <= 1'b0;
    end else begin
      noref_q <= noref_now;
      if (wr_stb) begin
        data_q <= noref_now ? {DATA_W{1'b1}} : wr_data;
        err_q  <= wr_clamp | noref_now;
        chan_q <= wr_chan;
      end
    end
  end

  assign par_bit = par_en & odd_ones(64'(data_q));

  a_r7_clamp_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && refdet_en && ref_low) |=> (&data_q && err_q));
  a_r6_err_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !wr_clamp && !(refdet_en && ref_low)) |=> !err_q);
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(data_q) && $stable(err_q) && $stable(chan_q)));
endmodule

// File: rtl/adc_stat_shift.sv
module adc_stat_shift
  import adc_stat_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic              append_en,
  input  logic [DATA_W-1:0] data_in,
  input  logic [STAT_W-1:0] stat_in,
  output logic              ser_out,
  output logic              ser_busy
);
  localparam int FRAME_W = DATA_W + STAT_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] sh_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (rd_stb) begin
      sh_q  <= {data_in, append_en ? stat_in : {STAT_W{1'b0}}};
      cnt_q <= append_en ? CNT_W'(FRAME_W) : CNT_W'(DATA_W);
    end else if (cnt_q != '0) begin
      sh_q  <= {sh_q[FRAME_W-2:0], 1'b0};
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ser_busy = (cnt_q != '0);
  assign ser_out  = ser_busy & sh_q[FRAME_W-1];

  a_r10_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_busy && !rd_stb) |=> (cnt_q == $past(cnt_q) - 1'b1));
  a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_busy |-> !ser_out);
endmodule

// File: rtl/adc_stat_core.sv
module adc_stat_core
  import adc_stat_pkg::*;
#(
  parameter int DATA_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic              wr_clamp,
  input  logic              ref_low,
  input  logic              rd_stb,
  input  logic              warn_stb,
  input  logic              pwr_down,
  input  logic              idle,
  input  logic              sync_n,
  input  logic              par_en,
  input  logic              refdet_en,
  input  logic              append_en,
  output logic [STAT_W-1:0] status_byte,
  output logic [DATA_W-1:0] data_q,
  output logic              ser_out,
  output logic              ser_busy
);
  logic              force_set;
  logic              rdy_q, err_q, noref_q, par_bit;
  logic [CHAN_W-1:0] chan_q;

  assign force_set = pwr_down | idle | ~sync_n;

  adc_stat_rdy u_rdy (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .warn_stb(warn_stb), .force_set(force_set), .rdy_q(rdy_q)
  );

  adc_stat_store #(.DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .wr_chan(wr_chan), .wr_clamp(wr_clamp), .ref_low(ref_low),
    .refdet_en(refdet_en), .par_en(par_en), .data_q(data_q),
    .err_q(err_q), .noref_q(noref_q), .chan_q(chan_q), .par_bit(par_bit)
  );

  assign status_byte = pack_status(rdy_q, err_q, noref_q, par_bit, chan_q);

  adc_stat_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .append_en(append_en),
    .data_in(data_q), .stat_in(status_byte), .ser_out(ser_out),
    .ser_busy(ser_busy)
  );

  a_r9_chan_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (status_byte[CHAN_W-1:0] == $past(wr_chan)));
  a_r8_parity_off: assert property (@(posedge clk) disable iff (!rst_n)
    !par_en |-> !status_byte[PAR_BIT]);
endmodule

// File: tb/adc_stat_core_tb.sv
module adc_stat_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 24;

  logic clk = 0, rst_n = 0;
  logic wr_stb = 0, wr_clamp = 0, ref_low = 0, rd_stb = 0, warn_stb = 0;
  logic pwr_down = 0, idle = 0, sync_n = 1, par_en = 0, refdet_en = 0, append_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [3:0] wr_chan = '0;
  logic [7:0] status_byte;
  logic [DW-1:0] data_q;
  logic ser_out, ser_busy;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_stat_core dut_i (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_data(wr_data),
    .wr_chan(wr_chan), .wr_clamp(wr_clamp), .ref_low(ref_low),
    .rd_stb(rd_stb), .warn_stb(warn_stb), .pwr_down(pwr_down),
    .idle(idle), .sync_n(sync_n), .par_en(par_en),
    .refdet_en(refdet_en), .append_en(append_en),
    .status_byte(status_byte), .data_q(data_q), .ser_out(ser_out),
    .ser_busy(ser_busy)
  );

  function automatic logic [7:0] exp_stat(input logic r, input logic e,
      input logic n, input logic p, input logic [3:0] c);
    return (8'(r) << 7) | (8'(e) << 6) | (8'(n) << 5) | (8'(p) << 4) | 8'(c);
  endfunction

  function automatic logic ones_odd(input logic [DW-1:0] v);
    int cnt = 0;
    for (int i = 0; i < DW; i++) cnt += int'(v[i]);
    return (cnt % 2) == 1;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic tick; @(posedge clk); @(negedge clk); endtask

  task automatic do_write(input logic [DW-1:0] d, input logic [3:0] c, input logic cl);
    wr_stb = 1; wr_data = d; wr_chan = c; wr_clamp = cl;
    tick();
    wr_stb = 0; wr_clamp = 0;
  endtask

  task automatic pulse_rd; rd_stb = 1; tick(); rd_stb = 0; endtask

  task automatic t_reset;
    chk("R1 status", 32'(status_byte), 32'h80);
    chk("R1 data", 32'(data_q), 0);
    chk("R1 busy", 32'(ser_busy), 0);
    chk("R1 ser_out", 32'(ser_out), 0);
  endtask

  task automatic t_write_basic;
    par_en = 1;
    do_write(24'h123456, 4'd3, 0);
    chk("R2/R3/R8/R9 status", 32'(status_byte),
        32'(exp_stat(0, 0, 0, ones_odd(24'h123456), 4'd3)));
    chk("R8 odd parity", 32'(status_byte[4]), 1);
    chk("R3 data", 32'(data_q), 32'h123456);
    do_write(24'h000003, 4'd9, 0);
    chk("R8 even parity", 32'(status_byte), 32'(exp_stat(0, 0, 0, 0, 4'd9)));
  endtask

  task automatic t_read_warn;
    pulse_rd();
    chk("R4 read sets ready", 32'(status_byte[7]), 1);
    do_write(24'h0000F0, 4'd2, 0);
    chk("R3 ready cleared", 32'(status_byte[7]), 0);
    warn_stb = 1; tick(); warn_stb = 0;
    chk("R4 warn sets ready", 32'(status_byte[7]), 1);
  endtask

  task automatic t_rdwr;
    rd_stb = 1; wr_stb = 1; wr_data = 24'h00000F; wr_chan = 4'd6;
    tick(); rd_stb = 0; wr_stb = 0;
    chk("R11 write wins", 32'(status_byte[7]), 0);
    repeat (DW + 2) tick();
  endtask

  task automatic t_clamp;
    do_write(24'hFFFFFF, 4'd1, 1);
    chk("R6 error set", 32'(status_byte[6]), 1);
    do_write(24'h000101, 4'd1, 0);
    chk("R6 error cleared", 32'(status_byte[6]), 0);
  endtask

  task automatic t_noref;
    refdet_en = 1; ref_low = 1; tick();
    chk("R7 noref bit", 32'(status_byte[5]), 1);
    do_write(24'h000001, 4'd4, 0);
    chk("R7 forced ones", 32'(data_q), 32'hFFFFFF);
    chk("R6 error on noref", 32'(status_byte[6]), 1);
    refdet_en = 0; tick();
    chk("R7 disabled bit", 32'(status_byte[5]), 0);
    do_write(24'h000001, 4'd4, 0);
    chk("R7 disabled data", 32'(data_q), 32'h000001);
    ref_low = 0;
    par_en = 0; tick();
    chk("R8 parity disabled", 32'(status_byte[4]), 0);
    par_en = 1;
  endtask

  task automatic t_force;
    do_write(24'h000010, 4'd7, 0);
    pwr_down = 1; tick();
    chk("R5 power-down", 32'(status_byte[7]), 1);
    do_write(24'h000020, 4'd8, 0);
    chk("R5 write under force", 32'(status_byte[7]), 1);
    pwr_down = 0;
    do_write(24'h000010, 4'd7, 0);
    idle = 1; tick(); idle = 0;
    chk("R5 idle", 32'(status_byte[7]), 1);
    do_write(24'h000010, 4'd7, 0);
    sync_n = 0; tick(); sync_n = 1;
    chk("R5 sync low", 32'(status_byte[7]), 1);
  endtask

  task automatic t_hold;
    logic [7:0] s0;
    do_write(24'h00ABCD, 4'd5, 1);
    s0 = status_byte;
    wr_data = 24'h555555; wr_chan = 4'd12; wr_clamp = 0;
    warn_stb = 1; tick(); warn_stb = 0; tick();
    chk("R12 data held", 32'(data_q), 32'h00ABCD);
    chk("R9/R12 chan and error held", 32'(status_byte[6:0]), 32'(s0[6:0]));
    repeat (2) tick();
  endtask

  task automatic t_serial(input logic app);
    logic [31:0] frame;
    logic [7:0] st;
    int n;
    do_write(24'hA5C30F, 4'd5, 0);
    st = exp_stat(0, 0, 0, ones_odd(24'hA5C30F), 4'd5);
    n = app ? 32 : 24;
    frame = app ? {24'hA5C30F, st} : {8'h00, 24'hA5C30F};
    append_en = app;
    pulse_rd();
    for (int k = 0; k < n; k++) begin
      chk(app ? "R10/R2 append bit" : "R10 data bit", 32'(ser_out), 32'(frame[n-1-k]));
      if (ser_busy !== 1'b1) chk("R10 busy", 32'(ser_busy), 1);
      tick();
    end
    chk("R10 busy ends", 32'(ser_busy), 0);
    chk("R10 idle out", 32'(ser_out), 0);
    append_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tick();
    t_reset();
    t_write_basic();
    t_read_warn();
    t_rdwr();
    t_clamp();
    t_noref();
    t_force();
    t_hold();
    t_serial(0);
    t_serial(1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule